// File: doc/BRIEF.md
# Directional Indirect Pixel Writer

This block lets a host put pixel data anywhere in a framebuffer through a small register window instead of a direct memory path. The host loads a linear destination address, a per-pixel write mask, foreground and background colours and a pixel format. It then pushes 32-bit data words into one of eight data aliases. Each word is turned into pixels, either by colour expansion or by direct pass-through, and written as one byte-enabled memory write at the current destination address. The destination then moves by a step that depends on which alias received the word.

Pixels are long-aligned: every pixel takes 4 bytes, so one framebuffer row of 2048 pixels spans 8192 bytes. A horizontal step moves by the pixel count carried in one word. A vertical step moves by one row. Data words are left-aligned. Bit 31 always describes the pixel with the lowest X. The block suits glyph drawing: the host sets a mask as wide as the glyph, then writes one word per scan line through the down-stepping alias.

Top module: `indirect_pixel_writer`

## Requirements
- R1: After reset the destination reads 0, no memory write is issued, all byte enables are 0, the mask is all ones, the format is expansion with an opaque background, and both colours are 0.
- R2: The eight data aliases are at offsets 0x600 + 0x20*k. In order k = 0..7 they step +X, +Y, -Y, -X, +X+Y, -X+Y, +X-Y, -X-Y. A vertical component adds or subtracts 8192 bytes.
- R3: A horizontal component moves the destination by 4 bytes times the pixels per word: 128 bytes for expansion (format 0), 16 bytes for 8-bit (format 1), 4 bytes for 32-bit (format 2 or 3).
- R4: A diagonal alias applies its horizontal and vertical components together in a single step.
- R5: The destination wraps modulo 2^24 in both directions.
- R6: In expansion format, word bit 31-p selects the colour of pixel p: set gives the foreground, clear gives the background. Pixel p sits at mem_data[32p+:32] with enables mem_be[4p+:4].
- R7: When mode bit 4 is set, expansion pixels whose data bit is clear get all four byte enables cleared.
- R8: Mask bit 31-p gates pixel p. A clear bit clears that pixel's enables in every format.
- R9: In 8-bit format, byte 3-p of the word (p = 0..3) goes to the low byte of pixel p with enable 0001. Pixels 4 and up have data 0 and enable 0.
- R10: In 32-bit format, the whole word is pixel 0 with enable 1111. All other pixels have data 0 and enable 0.
- R11: mem_we is high in exactly the cycle after a data-alias write. mem_addr then holds the destination from before the step, and cur_dst already holds the stepped value.
- R12: Any other write leaves the destination unchanged and issues no memory write. This covers misaligned offsets inside the alias window and offsets outside it. The other registers are destination 0x100, mask 0x104, foreground 0x108, background 0x10C and mode 0x110 (bits 1:0 format, bit 4 transparent background).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register byte offset |
| wr_data | input | 32 | Register write data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 24 | Linear byte address of pixel 0 |
| mem_data | output | 1024 | Pixel data, 32 bits per pixel |
| mem_be | output | 128 | Byte enables, 4 per pixel |
| cur_dst | output | 24 | Current destination address, for test |

## Verification
The hardest states to reach are the wrap cases. Walking there by real steps would take thousands of rows. Instead, the stimulus loads the destination register directly with a value a few bytes from either end of the address space, then issues a single +X or -Y write. A glyph sequence of twenty down-stepping writes under a narrow mask checks how masking and vertical stepping combine row by row. A behavioural model predicts every output on every clock throughout.

// File: rtl/indirect_pixel_writer.sv
module indirect_pixel_writer #(
  parameter int ADDR_W  = 24,
  parameter int ROW_PIX = 2048,
  parameter int OFS_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [OFS_W-1:0]    wr_addr,
  input  logic [31:0]         wr_data,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [32*32-1:0]    mem_data,
  output logic [32*4-1:0]     mem_be,
  output logic [ADDR_W-1:0]   cur_dst
);
  localparam int NPIX = 32;
  localparam int BPP  = 4;
  localparam int PITCH = ROW_PIX * BPP;
  localparam logic [ADDR_W-1:0] PITCH_A = ADDR_W'(PITCH);
  localparam logic [OFS_W-1:0] OFS_DST  = OFS_W'(12'h100);
  localparam logic [OFS_W-1:0] OFS_MASK = OFS_W'(12'h104);
  localparam logic [OFS_W-1:0] OFS_FG   = OFS_W'(12'h108);
  localparam logic [OFS_W-1:0] OFS_BG   = OFS_W'(12'h10C);
  localparam logic [OFS_W-1:0] OFS_MODE = OFS_W'(12'h110);
  localparam logic [OFS_W-1:0] OFS_DAT0 = OFS_W'(12'h600);

  logic [ADDR_W-1:0] dst_q;
  logic [31:0]       mask_q, fg_q, bg_q;
  logic [1:0]        fmt_q;
  logic              transp_q;

  logic [OFS_W-1:0]  rel;
  logic              alias_hit;
  logic [2:0]        dir;
  logic              x_inc, x_dec, y_inc, y_dec;
  logic [ADDR_W-1:0] hstep, dst_next;
  logic [NPIX*32-1:0] pix_data;
  logic [NPIX*4-1:0]  pix_be;

  assign rel       = wr_addr - OFS_DAT0;
  assign alias_hit = wr_en && (rel < OFS_W'(256)) && (rel[4:0] == 5'd0);
  assign dir       = rel[7:5];
  assign cur_dst   = dst_q;

  always_comb begin
    x_inc = 1'b0; x_dec = 1'b0; y_inc = 1'b0; y_dec = 1'b0;
    case (dir)
      3'd0: x_inc = 1'b1;
      3'd1: y_inc = 1'b1;
      3'd2: y_dec = 1'b1;
      3'd3: x_dec = 1'b1;
      3'd4: begin x_inc = 1'b1; y_inc = 1'b1; end
      3'd5: begin x_dec = 1'b1; y_inc = 1'b1; end
      3'd6: begin x_inc = 1'b1; y_dec = 1'b1; end
      default: begin x_dec = 1'b1; y_dec = 1'b1; end
    endcase
  end

  assign hstep = (fmt_q == 2'd0) ? ADDR_W'(NPIX * BPP) :
                 (fmt_q == 2'd1) ? ADDR_W'(4 * BPP) : ADDR_W'(BPP);

  assign dst_next = dst_q
                  + (x_inc ? hstep : '0) - (x_dec ? hstep : '0)
                  + (y_inc ? PITCH_A : '0) - (y_dec ? PITCH_A : '0);

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    logic bit_v, keep;
    assign bit_v = wr_data[31-p];
    assign keep  = mask_q[31-p];
    if (p == 0) begin : g_first
      always_comb begin
        case (fmt_q)
          2'd0: begin
            pix_data[p*32 +: 32] = bit_v ? fg_q : bg_q;
            pix_be[p*4 +: 4]     = (keep && (bit_v || !transp_q)) ? 4'hF : 4'h0;
          end
          2'd1: begin
            pix_data[p*32 +: 32] = {24'd0, wr_data[31:24]};
            pix_be[p*4 +: 4]     = keep ? 4'h1 : 4'h0;
          end
          default: begin
            pix_data[p*32 +: 32] = wr_data;
            pix_be[p*4 +: 4]     = keep ? 4'hF : 4'h0;
          end
        endcase
      end
    end else if (p < 4) begin : g_byte
      always_comb begin
        case (fmt_q)
          2'd0: begin
            pix_data[p*32 +: 32] = bit_v ? fg_q : bg_q;
            pix_be[p*4 +: 4]     = (keep && (bit_v || !transp_q)) ? 4'hF : 4'h0;
          end
          2'd1: begin
            pix_data[p*32 +: 32] = {24'd0, wr_data[31-8*p -: 8]};
            pix_be[p*4 +: 4]     = keep ? 4'h1 : 4'h0;
          end
          default: begin
            pix_data[p*32 +: 32] = 32'd0;
            pix_be[p*4 +: 4]     = 4'h0;
          end
        endcase
      end
    end else begin : g_exp
      assign pix_data[p*32 +: 32] = (fmt_q == 2'd0) ? (bit_v ? fg_q : bg_q) : 32'd0;
      assign pix_be[p*4 +: 4] = ((fmt_q == 2'd0) && keep && (bit_v || !transp_q)) ? 4'hF : 4'h0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_q    <= '0;
      mask_q   <= '1;
      fg_q     <= '0;
      bg_q     <= '0;
      fmt_q    <= 2'd0;
      transp_q <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      mem_be   <= '0;
    end else begin
      mem_we <= alias_hit;
      if (alias_hit) begin
        mem_addr <= dst_q;
        mem_data <= pix_data;
        mem_be   <= pix_be;
        dst_q    <= dst_next;
      end else begin
        mem_be <= '0;
        if (wr_en) begin
          if (wr_addr == OFS_DST)  dst_q  <= wr_data[ADDR_W-1:0];
          if (wr_addr == OFS_MASK) mask_q <= wr_data;
          if (wr_addr == OFS_FG)   fg_q   <= wr_data;
          if (wr_addr == OFS_BG)   bg_q   <= wr_data;
          if (wr_addr == OFS_MODE) begin
            fmt_q    <= wr_data[1:0];
            transp_q <= wr_data[4];
          end
        end
      end
    end
  end

  AST_WRITE_FOLLOWS_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(wr_en)) else $error("write without strobe"); // R11
  AST_ADDR_IS_OLD_DST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && alias_hit |=> mem_addr == $past(cur_dst)) else $error("addr"); // R11
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == OFS_DAT0 + OFS_W'(12'h20) |=> cur_dst == $past(cur_dst) + PITCH_A)
    else $error("down step"); // R2
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == OFS_DAT0 + OFS_W'(12'h40) |=> cur_dst == $past(cur_dst) - PITCH_A)
    else $error("up step"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cur_dst) && !mem_we) else $error("idle"); // R12
  AST_WIDE_PIXEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && alias_hit && fmt_q[1] |=> mem_be[NPIX*4-1:4] == '0) else $error("32b lanes"); // R10
endmodule

// File: tb/test_indirect_pixel_writer.sv
module test_indirect_pixel_writer;
  localparam int PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic mem_we;
  logic [23:0] mem_addr, cur_dst;
  logic [1023:0] mem_data;
  logic [127:0] mem_be;
  int total = 0, bad = 0;
  string cur_req = "R1";
  bit done = 0;

  indirect_pixel_writer i_indirect_pixel_writer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
    .cur_dst(cur_dst));

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference model
  longint m_dst; logic [31:0] m_mask, m_fg, m_bg; int m_fmt; bit m_tr;
  logic e_we; logic [23:0] e_addr; logic [1023:0] e_data; logic [127:0] e_be;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dst = 0; m_mask = '1; m_fg = 0; m_bg = 0; m_fmt = 0; m_tr = 0;
      e_we = 0; e_addr = 0; e_data = 0; e_be = 0;
    end else begin
      int a; a = int'(wr_addr);
      e_we = 0; e_be = 0;
      if (wr_en) begin
        if (a >= 'h600 && a < 'h700 && a % 32 == 0) begin
          int k, dx, dy, npix;
          k = (a - 'h600) / 32;
          dx = (k == 0 || k == 4 || k == 6) ? 1 : (k == 3 || k == 5 || k == 7) ? -1 : 0;
          dy = (k == 1 || k == 4 || k == 5) ? 1 : (k == 2 || k == 6 || k == 7) ? -1 : 0;
          npix = (m_fmt == 0) ? 32 : (m_fmt == 1) ? 4 : 1;
          e_we = 1; e_addr = m_dst[23:0]; e_data = 0;
          for (int p = 0; p < 32; p++) begin
            bit b, m; b = wr_data[31-p]; m = m_mask[31-p];
            if (m_fmt == 0) begin
              e_data[p*32 +: 32] = b ? m_fg : m_bg;
              e_be[p*4 +: 4] = (m && (b || !m_tr)) ? 4'hF : 4'h0;
            end else if (p < npix) begin
              if (m_fmt == 1) begin
                e_data[p*32 +: 32] = (wr_data >> (24 - 8*p)) & 32'hFF;
                e_be[p*4 +: 4] = m ? 4'h1 : 4'h0;
              end else begin
                e_data[p*32 +: 32] = wr_data;
                e_be[p*4 +: 4] = m ? 4'hF : 4'h0;
              end
            end
          end
          m_dst = (m_dst + dx*npix*4 + dy*8192) & 64'hFFFFFF;
        end else if (a == 'h100) m_dst = wr_data & 32'hFFFFFF;
        else if (a == 'h104) m_mask = wr_data;
        else if (a == 'h108) m_fg = wr_data;
        else if (a == 'h10C) m_bg = wr_data;
        else if (a == 'h110) begin m_fmt = wr_data[1:0]; m_tr = wr_data[4]; end
      end
    end
  end

  task automatic chk(string req, string what, logic [1023:0] act, logic [1023:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(cur_req, "mem_we", 1024'(mem_we), 1024'(e_we));
    chk(cur_req, "cur_dst", 1024'(cur_dst), 1024'(m_dst[23:0]));
    chk(cur_req, "mem_be", 1024'(mem_be), 1024'(e_be));
    if (e_we) begin
      chk(cur_req, "mem_addr", 1024'(mem_addr), 1024'(e_addr));
      chk(cur_req, "mem_data", mem_data, e_data);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    #1;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "reset dst", 1024'(cur_dst), 0);
    chk("R1", "reset we", 1024'(mem_we), 0);
    chk("R1", "reset be", 1024'(mem_be), 0);

    cur_req = "R10";
    wr('h110, 2); wr('h600, 32'hDEADBEEF);
    chk("R10", "word", 1024'(mem_data[31:0]), 1024'(32'hDEADBEEF));
    chk("R10", "be", 1024'(mem_be), 1024'(128'hF));
    chk("R11", "addr", 1024'(mem_addr), 0);
    chk("R3", "dst +4", 1024'(cur_dst), 4);

    cur_req = "R9";
    wr('h110, 1); wr('h100, 32'h4000); wr('h600, 32'hAABBCCDD);
    chk("R9", "p0", 1024'(mem_data[31:0]), 1024'(32'hAA));
    chk("R9", "p3", 1024'(mem_data[127:96]), 1024'(32'hDD));
    chk("R9", "be", 1024'(mem_be), 1024'(128'h1111));
    chk("R3", "dst +16", 1024'(cur_dst), 1024'(24'h4010));

    cur_req = "R4";
    wr('h6A0, 32'h12345678);
    chk("R4", "-X+Y", 1024'(cur_dst), 1024'(24'h6000));

    cur_req = "R6";
    wr('h110, 0); wr('h108, 32'h11223344); wr('h10C, 32'h55667788);
    wr('h100, 32'h200); wr('h600, 32'h80000001);
    chk("R6", "p0 fg", 1024'(mem_data[31:0]), 1024'(32'h11223344));
    chk("R6", "p1 bg", 1024'(mem_data[63:32]), 1024'(32'h55667788));
    chk("R6", "p31 fg", 1024'(mem_data[1023:992]), 1024'(32'h11223344));
    chk("R6", "be", 1024'(mem_be), 1024'({128{1'b1}}));
    chk("R3", "dst +128", 1024'(cur_dst), 1024'(24'h280));

    cur_req = "R7";
    wr('h110, 32'h10); wr('h660, 32'hA0000000);
    chk("R7", "be", 1024'(mem_be), 1024'(128'hF0F));
    chk("R2", "-X", 1024'(cur_dst), 1024'(24'h200));

    cur_req = "R8";
    wr('h110, 0); wr('h104, 32'hFFF00000);
    base = 100*4 + 150*8192;
    wr('h100, 32'(base));
    for (int r = 0; r < 20; r++) begin
      wr('h620, 32'hFFFFFFFF);
      chk("R8", "glyph row addr", 1024'(mem_addr), 1024'(24'(base + r*8192)));
      chk("R8", "glyph be", 1024'(mem_be), 1024'({80'd0, {48{1'b1}}}));
    end
    chk("R2", "20 rows down", 1024'(cur_dst), 1024'(24'(base + 20*8192)));
    wr('h640, 0);
    chk("R2", "up", 1024'(cur_dst), 1024'(24'(base + 19*8192)));
    cur_req = "R4";
    wr('h6C0, 0);
    chk("R4", "+X-Y", 1024'(cur_dst), 1024'(24'(base + 18*8192 + 128)));

    cur_req = "R5";
    wr('h104, 32'hFFFFFFFF); wr('h110, 2);
    wr('h100, 32'hFFFFFC); wr('h600, 1);
    chk("R5", "wrap up", 1024'(cur_dst), 0);
    wr('h100, 32'h1000); wr('h640, 1);
    chk("R5", "wrap down", 1024'(cur_dst), 1024'(24'hFFF000));

    cur_req = "R12";
    wr('h604, 32'hFFFF);
    chk("R12", "misaligned no we", 1024'(mem_we), 0);
    chk("R12", "misaligned dst", 1024'(cur_dst), 1024'(24'hFFF000));
    wr('h700, 1); wr('h5E0, 1);
    chk("R12", "outside no we", 1024'(mem_we), 0);
    chk("R12", "outside dst", 1024'(cur_dst), 1024'(24'hFFF000));

    cur_req = "R11";
    @(negedge clk); wr_en = 1'b1; wr_addr = 'h600; wr_data = 32'h1;
    @(negedge clk); wr_addr = 'h620;
    @(negedge clk); wr_en = 1'b0; #1;
    chk("R11", "back-to-back addr", 1024'(mem_addr), 1024'(24'hFFF004));
    @(negedge clk); #1;
    chk("R11", "we drops", 1024'(mem_we), 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule